// File: doc/BRIEF.md
# Folded-Symmetry Systolic FIR Filter

This block is a single-rate, fully parallel FIR filter built as a systolic chain. It accepts one signed fixed-point sample per clock, marked by a valid flag, and returns one filtered sample per clock with its own valid flag. The filter has a fixed, data-independent latency.

The impulse response is either mirror-symmetric or mirror-antisymmetric, and a parameter picks which. Each mirrored pair of taps is folded onto one multiplier. A pre-adder, or a pre-subtractor in the antisymmetric case, combines the two delayed samples before they reach that multiplier. As a result, only the unique half of the coefficients is supplied, on a parallel port that the filter reads live.

The accumulator is kept at full precision, so the output never wraps for any input or coefficient value. A synchronous reset empties the delay line, the partial sums and the valid pipeline.

Top module: `fir_sym_systolic`

## Requirements
- R1: Let x'[n] be the sample captured on accepted cycle n. The output is y[n] = sum over i of h[i]·x'[n-i], for i from 0 to TAPS-1, in two's complement. It is carried at the full width DATA_W+COEF_W+ceil(log2(TAPS)) and never wraps, even for the most negative inputs and coefficients.
- R2: A new sample can be presented on every cycle. The result for a sample presented with in_valid high appears HALF+2 cycles later, where HALF = ceil(TAPS/2). On that same cycle out_valid is high, and out_valid is low in every other cycle.
- R3: coefs carries HALF values. Value j is in bits [j·COEF_W +: COEF_W] and is signed. With ANTISYM=0 it sets h[j] = h[TAPS-1-j] = c[j]. Index 0 weights the newest sample.
- R4: With ANTISYM=1 the response is h[j] = c[j] and h[TAPS-1-j] = -c[j], for j < TAPS/2.
- R5: When TAPS is odd, the centre coefficient c[HALF-1] is applied exactly once, to the sample at h index HALF-1.
- R6: A zero in coefs removes that tap pair from the sum. Zero entries must still be present on the port.
- R7: A cycle with in_valid low enters the filter as a zero sample. Its in_data has no effect on any output.
- R8: coefs is read live, with no load strobe. Once the filter holds no nonzero samples, a new vector applies in full to the very next sample accepted.
- R9: rst is synchronous and active high. In the cycle after it is applied, out_valid is 0 and out_data is 0. No sample accepted before the reset contributes to any output after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of data and control paths |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DATA_W | Signed input sample |
| coefs | input | HALF·COEF_W | Unique half of the signed coefficients; c[0] in the low bits |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | ACC_W | Signed full-precision filtered sample |

## Verification
The hardest state to reach from the ports is a reset that lands while partial sums for several samples are still travelling down the cascade. The stimulus fills the chain with nonzero samples and asserts rst without draining it first. Every result that follows is then checked against a model that treats all pre-reset history as zero. A second hard case is a coefficient change with no strobe. It is reached by draining the filter with idle cycles, switching the vector on the port, and streaming at once, including full-scale negative samples and coefficients that stress the accumulator width.

// File: rtl/fir_pkg.sv
package fir_pkg;
  function automatic int half_count(input int taps);
    return (taps + 1) / 2;
  endfunction

  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction
endpackage

// File: rtl/fir_tapline.sv
module fir_tapline #(
  parameter int W    = 16,
  parameter int LEN  = 7,
  parameter int HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      in_data,
  output logic [HALF*W-1:0] near_taps,
  output logic [W-1:0]      far_tap
);
  logic [W-1:0] line [LEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEN; i++) line[i] <= '0;
    end else begin
      line[0] <= in_valid ? in_data : '0;
      for (int i = 1; i < LEN; i++) line[i] <= line[i-1];
    end
  end

  // stage j sees its near sample two positions further down per stage
  for (genvar j = 0; j < HALF; j++) begin : g_near
    assign near_taps[j*W +: W] = line[2*j];
  end
  assign far_tap = line[LEN-1];

  // idle input cycles load a zero sample into the line head
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> near_taps[W-1:0] == '0);
endmodule

// File: rtl/fir_cell.sv
module fir_cell #(
  parameter int  DATA_W   = 16,
  parameter int  COEF_W   = 16,
  parameter int  ACC_W    = 35,
  parameter bit  SUBTRACT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] near,
  input  logic [DATA_W-1:0] far,
  input  logic [COEF_W-1:0] coef,
  input  logic [ACC_W-1:0]  acc_in,
  output logic [ACC_W-1:0]  acc_out
);
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  logic signed [PRE_W-1:0]  near_x, far_x, pre;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x;

  assign near_x = PRE_W'($signed(near));
  assign far_x  = PRE_W'($signed(far));

  if (SUBTRACT) begin : g_sub
    assign pre = near_x - far_x;
  end else begin : g_add
    assign pre = near_x + far_x;
  end

  assign prod   = pre * $signed(coef);
  assign prod_x = prod;

  always_ff @(posedge clk) begin
    if (rst) acc_out <= '0;
    else     acc_out <= $signed(acc_in) + prod_x;
  end

  // a zero coefficient passes the incoming partial sum through unchanged
  assert_zero_coef_pass_R6: assert property (@(posedge clk) disable iff (rst)
    coef == '0 |=> acc_out == $past(acc_in));
endmodule

// File: rtl/fir_sym_systolic.sv
module fir_sym_systolic
  import fir_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int TAPS    = 7,
  parameter bit ANTISYM = 1'b0,
  localparam int HALF   = half_count(TAPS),
  localparam int ACC_W  = acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  input  logic [HALF*COEF_W-1:0] coefs,
  output logic                   out_valid,
  output logic [ACC_W-1:0]       out_data
);
  localparam int  LAT     = HALF + 2;
  localparam bit  ODD     = (TAPS % 2) == 1;

  logic [HALF*DATA_W-1:0] near_taps;
  logic [DATA_W-1:0]      far_tap;
  logic [ACC_W-1:0]       chain [HALF+1];
  logic [LAT-1:0]         vpipe;

  fir_tapline #(.W(DATA_W), .LEN(TAPS), .HALF(HALF)) u_line (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .near_taps (near_taps),
    .far_tap   (far_tap)
  );

  assign chain[0] = '0;

  for (genvar j = 0; j < HALF; j++) begin : g_cell
    localparam bit CENTRE = ODD && (j == HALF - 1);
    logic [DATA_W-1:0] far_op;
    if (CENTRE) begin : g_solo
      assign far_op = '0;
    end else begin : g_pair
      assign far_op = far_tap;
    end
    fir_cell #(
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .ACC_W    (ACC_W),
      .SUBTRACT (ANTISYM)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .near    (near_taps[j*DATA_W +: DATA_W]),
      .far     (far_op),
      .coef    (coefs[j*COEF_W +: COEF_W]),
      .acc_in  (chain[j]),
      .acc_out (chain[j+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe    <= '0;
      out_data <= '0;
    end else begin
      vpipe    <= {vpipe[LAT-2:0], in_valid};
      out_data <= chain[HALF];
    end
  end
  assign out_valid = vpipe[LAT-1];

  // checker state: any sample accepted since reset
  logic seen_any;
  always_ff @(posedge clk) begin
    if (rst)           seen_any <= 1'b0;
    else if (in_valid) seen_any <= 1'b1;
  end

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_valid_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen_any);
endmodule

// File: tb/sim_fir_sym_systolic.sv
module sim_fir_sym_systolic;
  localparam int DW = 16, CW = 16;
  localparam int L0 = 7, H0 = 4, LAT0 = 6, AW0 = 35;
  localparam int L1 = 6, H1 = 3, LAT1 = 5, AW1 = 35;
  localparam int MAXS = 600;
  localparam int NSTIM = 16;
  localparam logic [16:0] STIM [0:NSTIM-1] = '{
    {1'b1, 16'sd100},   {1'b1, -16'sd3},     {1'b0, 16'sd7777},  {1'b1, 16'sd250},
    {1'b1, 16'sd1},     {1'b0, -16'sd500},   {1'b1, -16'sd1200}, {1'b1, 16'sd32767},
    {1'b1, -16'sd32768},{1'b0, 16'sd12345},  {1'b1, 16'sd42},    {1'b1, 16'sd0},
    {1'b1, -16'sd7},    {1'b0, -16'sd1},     {1'b1, 16'sd999},   {1'b1, -16'sd64}
  };

  logic clk = 0, rst = 1, in_valid = 0;
  logic [DW-1:0] in_data = '0;
  logic [H0*CW-1:0] coef0 = '0;
  logic [H1*CW-1:0] coef1 = '0;
  logic out_valid0, out_valid1;
  logic [AW0-1:0] out0;
  logic [AW1-1:0] out1;

  always #5 clk = ~clk;

  fir_sym_systolic #(.DATA_W(DW), .COEF_W(CW), .TAPS(L0), .ANTISYM(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coefs(coef0), .out_valid(out_valid0), .out_data(out0));

  fir_sym_systolic #(.DATA_W(DW), .COEF_W(CW), .TAPS(L1), .ANTISYM(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coefs(coef1), .out_valid(out_valid1), .out_data(out1));

  int tests = 0, fails = 0, s = 0, base = 0;
  bit finished = 0;
  longint xe [0:MAXS-1];
  bit     vh [0:MAXS-1];
  longint c0 [0:H0-1];
  longint c1 [0:H1-1];

  function automatic longint h0(int i);
    return (i < H0) ? c0[i] : c0[L0-1-i];
  endfunction

  function automatic longint h1(int i);
    return (i < H1) ? c1[i] : -c1[L1-1-i];
  endfunction

  function automatic longint model(int which, int idx);
    longint acc = 0;
    int len = (which == 0) ? L0 : L1;
    for (int i = 0; i < len; i++) begin
      int k = idx - i;
      if (k >= base && k >= 0)
        acc += ((which == 0) ? h0(i) : h1(i)) * xe[k];
    end
    return acc;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", tag, act, exp, s);
    end
  endtask

  task automatic check_outputs(input string tag);
    int i0 = s - LAT0;
    int i1 = s - LAT1;
    longint ev0 = (i0 >= base) ? longint'(vh[i0]) : 0;
    longint ev1 = (i1 >= base) ? longint'(vh[i1]) : 0;
    check({tag, " valid u0"}, longint'(out_valid0), ev0);
    check({tag, " valid u1"}, longint'(out_valid1), ev1);
    check({tag, " data u0"}, longint'($signed(out0)), model(0, i0));
    check({tag, " data u1"}, longint'($signed(out1)), model(1, i1));
  endtask

  task automatic apply_coefs();
    for (int j = 0; j < H0; j++) coef0[j*CW +: CW] = c0[j][CW-1:0];
    for (int j = 0; j < H1; j++) coef1[j*CW +: CW] = c1[j][CW-1:0];
  endtask

  task automatic step(input bit v, input logic [DW-1:0] d, input string tag, input bit chk);
    if (chk) check_outputs(tag);
    in_valid = v;
    in_data  = d;
    vh[s] = v;
    xe[s] = v ? longint'($signed(d)) : 0;
    s++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h5a5a, tag, 1'b1);
  endtask

  task automatic do_reset();
    rst = 1;
    step(1'b0, '0, "", 1'b0);
    check("R9 reset valid u0", longint'(out_valid0), 0);
    check("R9 reset valid u1", longint'(out_valid1), 0);
    check("R9 reset data u0", longint'($signed(out0)), 0);
    check("R9 reset data u1", longint'($signed(out1)), 0);
    step(1'b0, '0, "", 1'b0);
    rst = 0;
    base = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    c0 = '{3, -5, 7, 11};
    c1 = '{2, -4, 9};
    apply_coefs();
    do_reset();

    // table walk: folding, antisymmetry, centre tap, idle-cycle data ignored
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < NSTIM; i++)
        step(STIM[i][16], STIM[i][15:0], "R1 R2 R3 R4 R5 R7", 1'b1);
    idle(14, "R2 R7 drain");

    // zero coefficients still on the port
    c0 = '{0, 6, 0, -2};
    c1 = '{0, 5, 0};
    apply_coefs();
    step(1'b1, 16'sd1, "R6 impulse", 1'b1);
    idle(3, "R6 R7");
    step(1'b1, -16'sd300, "R6", 1'b1);
    step(1'b1, 16'sd77, "R6", 1'b1);
    idle(14, "R6 drain");

    // live coefficient change with full-scale values
    c0 = '{-32768, -32768, -32768, -32768};
    c1 = '{-32768, 32767, -32768};
    apply_coefs();
    for (int i = 0; i < 10; i++) step(1'b1, 16'h8000, "R1 R8 full scale", 1'b1);
    step(1'b1, 16'h7fff, "R1 R8", 1'b1);
    step(1'b1, 16'h8000, "R1 R8", 1'b1);
    idle(14, "R8 drain");

    // reset with results still in flight
    c0 = '{1, 2, 3, 4};
    c1 = '{5, -6, 7};
    apply_coefs();
    for (int i = 0; i < 5; i++) step(1'b1, DW'(1000 + i), "R9 fill", 1'b1);
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, DW'(-20 * i), "R9 after reset", 1'b1);
    idle(14, "R9 drain");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule